// File: doc/BRIEF.md
# Limited-Pointer Coherence Directory with Overflow Trap

This block is the directory controller that sits beside one node's share of main memory in a distributed shared-memory multiprocessor. It keeps one entry per tracked memory block. Each entry holds a coherence state, a meta-state (normal or trap-on-write), a small fixed set of sharer pointers, a recorded owner and an acknowledgement counter. Each pointer is a node ID with its own valid bit. Read, write and invalidation-acknowledge messages arrive on a network-side request port. The controller answers each one a cycle later on a response port, and it issues invalidations to sharers on a separate vector port.

An entry stores only a few pointers rather than one presence bit per node, so it can run out of room. When a read needs a new slot and every pointer is taken, the controller stops handling the request in hardware. It raises a trap pulse to the local processor and marks the entry trap-pending. Software then keeps the full sharer set and drives the entry through a register-style port that can read or write every field of any entry.

Two software actions follow a trap. After the first overflow, software clears the pointers and sets the entry to trap-on-write, and later reads refill the pointers in hardware. A write to such an entry traps as well. Software then ends the episode: it records the writer as owner, loads the counter with the number of sharers it invalidated, and returns the entry to normal mode in the write-transaction state. The hardware counts the remaining acknowledgements down and grants the write.

Top module: `lptr_dir`

## Requirements
- R1: After reset every entry reads back as all zeros through the processor port: state idle (0), mode normal (0), no valid pointers, owner 0, counter 0, no trap pending. The response, invalidation and trap outputs are low.
- R2: A read to an idle (0) or shared (1) entry with a free pointer records the requester in the lowest-numbered free pointer and sets the state to shared. The next cycle brings response code read-grant (0). Entry bits, from LSB: pointer k ID at [k*NODE_W +: NODE_W], then the PTRS valid bits, counter (CNT_W), owner (NODE_W), state (3), mode (1), trap-pending (1).
- R3: A read from a node already held in a valid pointer is granted and does not use a second pointer.
- R4: A read that needs a new pointer when all are valid gives response code trapped (3) and a trap pulse carrying the entry index, the node and write flag 0. It sets trap-pending and leaves the pointers unchanged.
- R5: A write (op 1) to a shared entry in normal mode invalidates every valid pointer whose ID differs from the writer. Invalidation bit k carries pointer k's ID in slot k. The write then clears the pointers, records the writer as owner and loads the counter with the number invalidated, moving to write-transaction (3) with no response. If nobody needs invalidating, the write is granted at once (code 1) and the state becomes exclusive (2). A write to an idle entry is also granted at once.
- R6: Each acknowledgement (op 2) to an entry in write-transaction decrements the counter. The acknowledgement that brings it to zero issues a write grant to the owner and sets the state to exclusive.
- R7: A write to an idle or shared entry in trap-on-write mode (1) traps with write flag 1 and response code 3, and sets trap-pending.
- R8: In trap-on-write mode, reads fill free pointers in hardware and are granted as in normal mode.
- R9: A read or write to an entry that is trap-pending, in write-transaction, or in recall (4) gets busy (2). So does any request to an entry the processor writes in the same cycle; the processor's write takes effect.
- R10: The processor port reads any entry combinationally and writes any entire entry in one cycle.
- R11: After software terminates an overflow (normal mode, write-transaction, owner and counter loaded), the hardware counts the acknowledgements and grants the write to that owner.
- R12: In exclusive state, reads and writes by the owner are granted with no change. A write by another node invalidates the owner in slot 0, sets the counter to 1 and enters write-transaction with the new owner. A read by another node invalidates the owner, answers busy and enters recall; the recall's acknowledgement returns the entry to idle with no response.
- R13: An acknowledgement to an entry in any other state gives no response and leaves the entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Network request present |
| req_op | input | 2 | 0 read, 1 write, 2 invalidation acknowledge |
| req_idx | input | IDX_W | Directory entry addressed |
| req_node | input | NODE_W | Requesting node |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | 0 read grant, 1 write grant, 2 busy, 3 trapped |
| rsp_idx | output | IDX_W | Entry of the response |
| rsp_node | output | NODE_W | Destination node |
| inv_mask | output | PTRS | Invalidation per slot |
| inv_nodes | output | PTRS*NODE_W | Target node per slot |
| inv_idx | output | IDX_W | Entry being invalidated |
| trap_valid | output | 1 | Trap pulse to local processor |
| trap_idx | output | IDX_W | Entry that trapped |
| trap_node | output | NODE_W | Node whose request trapped |
| trap_write | output | 1 | 1 if the trapping request was a write |
| cpu_we | input | 1 | Processor writes entry cpu_idx |
| cpu_idx | input | IDX_W | Entry addressed by processor |
| cpu_wdata | input | ENTRY_W | Entry value to write |
| cpu_rdata | output | ENTRY_W | Current value of entry cpu_idx |

## Verification
The assertions check, on every cycle, the rules that follow from one request and the entry it meets. Blocked requests are answered busy. A read with a full pointer set and no match gives a trap together with a trapped response. A read that matches a pointer is granted without a trap. Responses and invalidations only follow real requests. The bench scenarios are needed for the multi-step behaviour: which slot fills, the exact invalidation vectors and counter values, the countdown to a write grant across several acknowledgements, the software hand-over sequence through trap-on-write and termination, recall, and the processor-write collision.

// File: rtl/lptr_dir_pkg.sv
// Shared encodings for the limited-pointer directory.
// Assumes: the request opcode is 2 bits and the state field is 3 bits.
package lptr_dir_pkg;
    typedef enum logic [1:0] {OP_READ = 2'd0, OP_WRITE = 2'd1, OP_ACK = 2'd2, OP_RSVD = 2'd3} op_e;
    typedef enum logic [1:0] {RSP_RD_GRANT = 2'd0, RSP_WR_GRANT = 2'd1, RSP_BUSY = 2'd2, RSP_TRAPPED = 2'd3} rsp_e;
    typedef enum logic [2:0] {ST_IDLE = 3'd0, ST_SHARED = 3'd1, ST_EXCL = 3'd2,
                              ST_WTXN = 3'd3, ST_RECALL = 3'd4} dstate_e;
    typedef enum logic {MODE_NORMAL = 1'b0, MODE_TOW = 1'b1} mode_e;
endpackage

// File: rtl/lptr_slot_scan.sv
// Pointer scan: compares a node ID against every pointer of one entry.
// Reports a hit, whether all pointers are in use, the lowest free slot,
// and which valid pointers hold a different node (with their count).
// Assumes: purely combinational, PTRS >= 1.
module lptr_slot_scan #(
    parameter int PTRS   = 4,
    parameter int NODE_W = 4,
    parameter int CNT_W  = 5,
    localparam int PIW   = (PTRS > 1) ? $clog2(PTRS) : 1
) (
    input  logic [PTRS-1:0]        pvalid,
    input  logic [PTRS*NODE_W-1:0] pids,
    input  logic [NODE_W-1:0]      node,
    output logic                   hit,
    output logic                   full,
    output logic [PIW-1:0]         free_slot,
    output logic [PTRS-1:0]        others,
    output logic [CNT_W-1:0]       others_cnt
);
    logic [PTRS-1:0] match;

    // Per-slot comparison of stored ID against the requester.
    for (genvar k = 0; k < PTRS; k++) begin : g_cmp
        assign match[k]  = pvalid[k] && (pids[k*NODE_W +: NODE_W] == node);
        assign others[k] = pvalid[k] && !match[k];
    end

    assign hit  = |match;
    assign full = &pvalid;

    // Lowest free slot, scanned from the top so the lowest wins.
    always_comb begin
        free_slot = '0;
        for (int k = PTRS - 1; k >= 0; k--) begin
            if (!pvalid[k]) free_slot = PIW'(k);
        end
    end

    // Count of sharers that need an invalidation.
    always_comb begin
        others_cnt = '0;
        for (int k = 0; k < PTRS; k++) begin
            others_cnt = others_cnt + CNT_W'(others[k]);
        end
    end
endmodule

// File: rtl/lptr_dir_store.sv
// Entry storage: ENTRIES flat entries, two combinational read ports and
// two write ports. Port b (processor) overrides port a on the same entry.
// Assumes: synchronous active-low reset clears every entry to zero.
module lptr_dir_store #(
    parameter int ENTRIES = 8,
    parameter int ENTRY_W = 34,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   a_idx,
    output logic [ENTRY_W-1:0] a_rd,
    input  logic               a_we,
    input  logic [ENTRY_W-1:0] a_wd,
    input  logic [IDX_W-1:0]   b_idx,
    output logic [ENTRY_W-1:0] b_rd,
    input  logic               b_we,
    input  logic [ENTRY_W-1:0] b_wd
);
    logic [ENTRY_W-1:0] mem [ENTRIES];

    assign a_rd = mem[a_idx];
    assign b_rd = mem[b_idx];

    // Update storage; the later processor write wins a same-entry clash.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else begin
            if (a_we) mem[a_idx] <= a_wd;
            if (b_we) mem[b_idx] <= b_wd;
        end
    end
endmodule

// File: rtl/lptr_dir.sv
// Limited-pointer directory controller. Handles network read, write and
// acknowledge requests against one entry per cycle, fills pointers,
// issues invalidations, counts acknowledgements and traps to the local
// processor on pointer overflow or on writes in trap-on-write mode.
// Assumes: at most one network request per cycle; all outputs registered
// (visible the cycle after the request); software handles trapped entries.
module lptr_dir
    import lptr_dir_pkg::*;
#(
    parameter int NODES   = 16,
    parameter int PTRS    = 4,
    parameter int ENTRIES = 8,
    localparam int NODE_W  = (NODES > 1) ? $clog2(NODES) : 1,
    localparam int CNT_W   = $clog2(NODES + 1),
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int ENTRY_W = 2 + 3 + NODE_W + CNT_W + PTRS + PTRS * NODE_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [1:0]             req_op,
    input  logic [IDX_W-1:0]       req_idx,
    input  logic [NODE_W-1:0]      req_node,
    output logic                   rsp_valid,
    output logic [1:0]             rsp_code,
    output logic [IDX_W-1:0]       rsp_idx,
    output logic [NODE_W-1:0]      rsp_node,
    output logic [PTRS-1:0]        inv_mask,
    output logic [PTRS*NODE_W-1:0] inv_nodes,
    output logic [IDX_W-1:0]       inv_idx,
    output logic                   trap_valid,
    output logic [IDX_W-1:0]       trap_idx,
    output logic [NODE_W-1:0]      trap_node,
    output logic                   trap_write,
    input  logic                   cpu_we,
    input  logic [IDX_W-1:0]       cpu_idx,
    input  logic [ENTRY_W-1:0]     cpu_wdata,
    output logic [ENTRY_W-1:0]     cpu_rdata
);
    localparam int PIW = (PTRS > 1) ? $clog2(PTRS) : 1;

    typedef struct packed {
        logic                   trap_pend;
        mode_e                  mode;
        dstate_e                state;
        logic [NODE_W-1:0]      owner;
        logic [CNT_W-1:0]       ack;
        logic [PTRS-1:0]        pvalid;
        logic [PTRS*NODE_W-1:0] pids;
    } ent_t;

    logic [ENTRY_W-1:0] net_rd;
    ent_t               ent, nxt;
    logic               ent_we;

    logic               s_hit, s_full;
    logic [PIW-1:0]     s_free;
    logic [PTRS-1:0]    s_others;
    logic [CNT_W-1:0]   s_cnt;

    logic                   cpu_clash;
    logic                   c_rsp_v;
    rsp_e                   c_rsp_code;
    logic [NODE_W-1:0]      c_rsp_node;
    logic [PTRS-1:0]        c_inv_mask;
    logic [PTRS*NODE_W-1:0] c_inv_nodes;
    logic                   c_trap_v, c_trap_w;

    // Observation points for the bound checker.
    logic [2:0] cur_state;
    logic       cur_trap;

    lptr_dir_store #(.ENTRIES(ENTRIES), .ENTRY_W(ENTRY_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .a_idx (req_idx),
        .a_rd  (net_rd),
        .a_we  (ent_we),
        .a_wd  (nxt),
        .b_idx (cpu_idx),
        .b_rd  (cpu_rdata),
        .b_we  (cpu_we),
        .b_wd  (cpu_wdata)
    );

    assign ent = ent_t'(net_rd);

    lptr_slot_scan #(.PTRS(PTRS), .NODE_W(NODE_W), .CNT_W(CNT_W)) u_scan (
        .pvalid     (ent.pvalid),
        .pids       (ent.pids),
        .node       (req_node),
        .hit        (s_hit),
        .full       (s_full),
        .free_slot  (s_free),
        .others     (s_others),
        .others_cnt (s_cnt)
    );

    assign cpu_clash = cpu_we && (cpu_idx == req_idx);
    assign cur_state = ent.state;
    assign cur_trap  = ent.trap_pend;

    // Protocol decision for the addressed entry: next entry and outputs.
    always_comb begin
        nxt         = ent;
        ent_we      = 1'b0;
        c_rsp_v     = 1'b0;
        c_rsp_code  = RSP_BUSY;
        c_rsp_node  = req_node;
        c_inv_mask  = '0;
        c_inv_nodes = '0;
        c_trap_v    = 1'b0;
        c_trap_w    = 1'b0;
        if (req_valid) begin
            if (cpu_clash) begin
                c_rsp_v = 1'b1;
            end else if (req_op == OP_ACK) begin
                if (ent.state == ST_WTXN || ent.state == ST_RECALL) begin
                    ent_we = 1'b1;
                    if (ent.ack <= CNT_W'(1)) begin
                        nxt.ack = '0;
                        if (ent.state == ST_WTXN) begin
                            nxt.state  = ST_EXCL;
                            c_rsp_v    = 1'b1;
                            c_rsp_code = RSP_WR_GRANT;
                            c_rsp_node = ent.owner;
                        end else begin
                            nxt.state = ST_IDLE;
                            nxt.owner = '0;
                        end
                    end else begin
                        nxt.ack = ent.ack - CNT_W'(1);
                    end
                end
            end else if (req_op == OP_READ || req_op == OP_WRITE) begin
                c_rsp_v = 1'b1;
                if (ent.trap_pend || ent.state == ST_WTXN || ent.state == ST_RECALL) begin
                    c_rsp_code = RSP_BUSY;
                end else if (req_op == OP_READ) begin
                    if (ent.state == ST_EXCL) begin
                        if (ent.owner == req_node) begin
                            c_rsp_code = RSP_RD_GRANT;
                        end else begin
                            ent_we                    = 1'b1;
                            nxt.state                 = ST_RECALL;
                            nxt.ack                   = CNT_W'(1);
                            c_inv_mask[0]             = 1'b1;
                            c_inv_nodes[0 +: NODE_W]  = ent.owner;
                            c_rsp_code                = RSP_BUSY;
                        end
                    end else if (s_hit) begin
                        c_rsp_code = RSP_RD_GRANT;
                    end else if (!s_full) begin
                        ent_we                                   = 1'b1;
                        nxt.state                                = ST_SHARED;
                        nxt.pvalid[s_free]                       = 1'b1;
                        nxt.pids[32'(s_free) * NODE_W +: NODE_W] = req_node;
                        c_rsp_code                               = RSP_RD_GRANT;
                    end else begin
                        ent_we        = 1'b1;
                        nxt.trap_pend = 1'b1;
                        c_rsp_code    = RSP_TRAPPED;
                        c_trap_v      = 1'b1;
                    end
                end else begin
                    if (ent.state == ST_EXCL) begin
                        if (ent.owner == req_node) begin
                            c_rsp_code = RSP_WR_GRANT;
                        end else begin
                            ent_we                   = 1'b1;
                            nxt.state                = ST_WTXN;
                            nxt.owner                = req_node;
                            nxt.ack                  = CNT_W'(1);
                            c_inv_mask[0]            = 1'b1;
                            c_inv_nodes[0 +: NODE_W] = ent.owner;
                            c_rsp_v                  = 1'b0;
                        end
                    end else if (ent.mode == MODE_TOW) begin
                        ent_we        = 1'b1;
                        nxt.trap_pend = 1'b1;
                        c_rsp_code    = RSP_TRAPPED;
                        c_trap_v      = 1'b1;
                        c_trap_w      = 1'b1;
                    end else begin
                        ent_we      = 1'b1;
                        nxt.pvalid  = '0;
                        nxt.pids    = '0;
                        nxt.owner   = req_node;
                        c_inv_mask  = s_others;
                        c_inv_nodes = ent.pids;
                        if (s_cnt == '0) begin
                            nxt.state  = ST_EXCL;
                            nxt.ack    = '0;
                            c_rsp_code = RSP_WR_GRANT;
                        end else begin
                            nxt.state = ST_WTXN;
                            nxt.ack   = s_cnt;
                            c_rsp_v   = 1'b0;
                        end
                    end
                end
            end
        end
    end

    // Register all network-facing outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_code   <= '0;
            rsp_idx    <= '0;
            rsp_node   <= '0;
            inv_mask   <= '0;
            inv_nodes  <= '0;
            inv_idx    <= '0;
            trap_valid <= 1'b0;
            trap_idx   <= '0;
            trap_node  <= '0;
            trap_write <= 1'b0;
        end else begin
            rsp_valid  <= c_rsp_v;
            rsp_code   <= c_rsp_code;
            rsp_idx    <= req_idx;
            rsp_node   <= c_rsp_node;
            inv_mask   <= c_inv_mask;
            inv_nodes  <= c_inv_nodes;
            inv_idx    <= req_idx;
            trap_valid <= c_trap_v;
            trap_idx   <= req_idx;
            trap_node  <= req_node;
            trap_write <= c_trap_w;
        end
    end
endmodule

// Property checker for lptr_dir, attached by the bind below.
// Assumes: the observation signals reflect the addressed entry this cycle.
module lptr_dir_chk
    import lptr_dir_pkg::*;
#(
    parameter int PTRS = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [1:0]      req_op,
    input logic [2:0]      cur_state,
    input logic            cur_trap,
    input logic            cur_full,
    input logic            cur_hit,
    input logic            cpu_clash,
    input logic            rsp_valid,
    input logic [1:0]      rsp_code,
    input logic            trap_valid,
    input logic [PTRS-1:0] inv_mask
);
    logic rd_open;
    assign rd_open = req_valid && req_op == OP_READ && !cpu_clash && !cur_trap
                     && (cur_state == ST_IDLE || cur_state == ST_SHARED);

    // R9: blocked reads and writes are answered busy.
    assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op == OP_READ || req_op == OP_WRITE)
         && (cur_trap || cur_state == ST_WTXN || cur_state == ST_RECALL))
        |=> (rsp_valid && rsp_code == RSP_BUSY));

    // R4: read with all pointers taken and no match traps.
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_open && cur_full && !cur_hit) |=> (trap_valid && rsp_code == RSP_TRAPPED));

    // R4: every trap pulse comes with a trapped response.
    assert_trap_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> (rsp_valid && rsp_code == RSP_TRAPPED));

    // R3: a read that matches a pointer is granted, never trapped.
    assert_hit_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_open && cur_hit) |=> (rsp_valid && rsp_code == RSP_RD_GRANT && !trap_valid));

    // R2: responses only follow a request.
    assert_rsp_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    // R5: invalidations only follow a read or write request.
    assert_inv_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|inv_mask) |-> $past(req_valid && (req_op == OP_READ || req_op == OP_WRITE)));
endmodule

bind lptr_dir lptr_dir_chk #(.PTRS(PTRS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .cur_state  (cur_state),
    .cur_trap   (cur_trap),
    .cur_full   (s_full),
    .cur_hit    (s_hit),
    .cpu_clash  (cpu_clash),
    .rsp_valid  (rsp_valid),
    .rsp_code   (rsp_code),
    .trap_valid (trap_valid),
    .inv_mask   (inv_mask)
);

// File: tb/lptr_dir_test.sv
// Directed scenario bench for lptr_dir; one task per scenario.
module lptr_dir_test;
    localparam int NODES = 16, PTRS = 4, ENTRIES = 8;
    localparam int NW = 4, CW = 5, IW = 3, EW = 34;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = '0;
    logic [IW-1:0] req_idx = '0;
    logic [NW-1:0] req_node = '0;
    logic rsp_valid, trap_valid, trap_write;
    logic [1:0] rsp_code;
    logic [IW-1:0] rsp_idx, inv_idx, trap_idx;
    logic [NW-1:0] rsp_node, trap_node;
    logic [PTRS-1:0] inv_mask;
    logic [PTRS*NW-1:0] inv_nodes;
    logic cpu_we = 1'b0;
    logic [IW-1:0] cpu_idx = '0;
    logic [EW-1:0] cpu_wdata = '0;
    logic [EW-1:0] cpu_rdata;

    int checks = 0, fails = 0;

    // Captured outputs of the last request.
    logic o_rv, o_tv, o_tw;
    logic [1:0] o_code;
    logic [NW-1:0] o_node, o_tnode;
    logic [PTRS-1:0] o_imask;
    logic [PTRS*NW-1:0] o_inodes;

    lptr_dir #(.NODES(NODES), .PTRS(PTRS), .ENTRIES(ENTRIES)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_idx(req_idx), .req_node(req_node), .rsp_valid(rsp_valid),
        .rsp_code(rsp_code), .rsp_idx(rsp_idx), .rsp_node(rsp_node),
        .inv_mask(inv_mask), .inv_nodes(inv_nodes), .inv_idx(inv_idx),
        .trap_valid(trap_valid), .trap_idx(trap_idx), .trap_node(trap_node),
        .trap_write(trap_write), .cpu_we(cpu_we), .cpu_idx(cpu_idx),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
    );

    always #5 clk = ~clk;

    function automatic logic [EW-1:0] mk(input logic tp, input logic md, input logic [2:0] st,
                                         input logic [NW-1:0] own, input logic [CW-1:0] ack,
                                         input logic [PTRS-1:0] pv, input logic [PTRS*NW-1:0] ids);
        return {tp, md, st, own, ack, pv, ids};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input int idx, input int node);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_idx = IW'(idx); req_node = NW'(node);
        @(posedge clk); #1;
        req_valid = 1'b0;
        o_rv = rsp_valid; o_code = rsp_code; o_node = rsp_node;
        o_tv = trap_valid; o_tw = trap_write; o_tnode = trap_node;
        o_imask = inv_mask; o_inodes = inv_nodes;
    endtask

    task automatic peek(input int idx, output logic [EW-1:0] d);
        @(negedge clk);
        cpu_idx = IW'(idx);
        #1 d = cpu_rdata;
    endtask

    task automatic poke(input int idx, input logic [EW-1:0] d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_idx = IW'(idx); cpu_wdata = d;
        @(posedge clk); #1;
        cpu_we = 1'b0;
    endtask

    task automatic t_reset();
        logic [EW-1:0] d;
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 trap_valid", trap_valid, 0);
        chk("R1 inv_mask", inv_mask, 0);
        peek(0, d); chk("R1 entry0", d, 0);
        peek(7, d); chk("R1 entry7", d, 0);
    endtask

    task automatic t_fill();
        logic [EW-1:0] d;
        issue(0, 1, 3); chk("R2 grant code", {o_rv, o_code}, {1'b1, 2'd0});
        chk("R2 grant node", o_node, 3);
        issue(0, 1, 5); chk("R2 second grant", {o_rv, o_code}, {1'b1, 2'd0});
        issue(0, 1, 3); chk("R3 repeat grant", {o_rv, o_code, o_tv}, {1'b1, 2'd0, 1'b0});
        peek(1, d); chk("R3 R10 entry1 slots", d, mk(0, 0, 1, 0, 0, 4'b0011, 16'h0053));
    endtask

    task automatic t_overflow();
        logic [EW-1:0] d;
        issue(0, 1, 7); issue(0, 1, 9);
        issue(0, 1, 11);
        chk("R4 trapped rsp", {o_rv, o_code}, {1'b1, 2'd3});
        chk("R4 trap pulse", {o_tv, o_tw, o_tnode}, {1'b1, 1'b0, 4'd11});
        chk("R4 trap idx", trap_idx, 1);
        peek(1, d); chk("R4 entry pend", d, mk(1, 0, 1, 0, 0, 4'b1111, 16'h9753));
        issue(0, 1, 3); chk("R9 busy on pend", {o_rv, o_code}, {1'b1, 2'd2});
    endtask

    task automatic t_software();
        logic [EW-1:0] d;
        poke(1, mk(0, 1, 1, 0, 0, 4'b0000, 16'h0));
        issue(0, 1, 2); chk("R8 tow read grant", {o_rv, o_code}, {1'b1, 2'd0});
        peek(1, d); chk("R8 tow refill", d, mk(0, 1, 1, 0, 0, 4'b0001, 16'h0002));
        issue(1, 1, 6);
        chk("R7 write trap", {o_rv, o_code, o_tv, o_tw, o_tnode}, {1'b1, 2'd3, 1'b1, 1'b1, 4'd6});
        poke(1, mk(0, 0, 3, 6, 3, 4'b0000, 16'h0));
        issue(0, 1, 2); chk("R9 busy in wtxn", {o_rv, o_code}, {1'b1, 2'd2});
        issue(2, 1, 2); chk("R11 ack1 silent", o_rv, 0);
        issue(2, 1, 3); chk("R11 ack2 silent", o_rv, 0);
        peek(1, d); chk("R6 count left", d, mk(0, 0, 3, 6, 1, 4'b0000, 16'h0));
        issue(2, 1, 5);
        chk("R11 write grant", {o_rv, o_code, o_node}, {1'b1, 2'd1, 4'd6});
        peek(1, d); chk("R11 exclusive", d, mk(0, 0, 2, 6, 0, 4'b0000, 16'h0));
    endtask

    task automatic t_write_shared();
        logic [EW-1:0] d;
        issue(0, 2, 1); issue(0, 2, 4); issue(0, 2, 8);
        issue(1, 2, 4);
        chk("R5 no rsp", o_rv, 0);
        chk("R5 inv mask", o_imask, 4'b0101);
        chk("R5 inv node0", o_inodes[3:0], 1);
        chk("R5 inv node2", o_inodes[11:8], 8);
        peek(2, d); chk("R5 entry wtxn", d, mk(0, 0, 3, 4, 2, 4'b0000, 16'h0));
        issue(2, 2, 1); chk("R6 first ack", o_rv, 0);
        issue(2, 2, 8); chk("R6 final grant", {o_rv, o_code, o_node}, {1'b1, 2'd1, 4'd4});
    endtask

    task automatic t_write_alone();
        logic [EW-1:0] d;
        issue(1, 4, 2); chk("R5 idle write grant", {o_rv, o_code, o_imask}, {1'b1, 2'd1, 4'b0});
        issue(0, 3, 5);
        issue(1, 3, 5); chk("R5 sole sharer grant", {o_rv, o_code, o_imask}, {1'b1, 2'd1, 4'b0});
        peek(3, d); chk("R5 entry3 excl", d, mk(0, 0, 2, 5, 0, 4'b0000, 16'h0));
    endtask

    task automatic t_excl();
        logic [EW-1:0] d;
        issue(0, 3, 5); chk("R12 owner read", {o_rv, o_code}, {1'b1, 2'd0});
        issue(1, 3, 9);
        chk("R12 write other", {o_rv, o_imask, o_inodes[3:0]}, {1'b0, 4'b0001, 4'd5});
        peek(3, d); chk("R12 wtxn", d, mk(0, 0, 3, 9, 1, 4'b0000, 16'h0));
        issue(2, 3, 5); chk("R12 grant new owner", {o_rv, o_code, o_node}, {1'b1, 2'd1, 4'd9});
        issue(0, 3, 12);
        chk("R12 recall", {o_rv, o_code, o_imask, o_inodes[3:0]}, {1'b1, 2'd2, 4'b0001, 4'd9});
        issue(2, 3, 9); chk("R12 recall ack silent", o_rv, 0);
        peek(3, d); chk("R12 back to idle", d, 0);
    endtask

    task automatic t_stray_ack();
        logic [EW-1:0] d;
        issue(2, 5, 1); chk("R13 no rsp", o_rv, 0);
        peek(5, d); chk("R13 unchanged", d, 0);
        issue(2, 2, 1); chk("R13 ack in excl", o_rv, 0);
        peek(2, d); chk("R13 excl unchanged", d, mk(0, 0, 2, 4, 0, 4'b0000, 16'h0));
    endtask

    task automatic t_clash();
        logic [EW-1:0] d;
        logic [EW-1:0] w;
        w = mk(0, 0, 1, 0, 0, 4'b0001, 16'h000A);
        @(negedge clk);
        cpu_we = 1'b1; cpu_idx = 6; cpu_wdata = w;
        req_valid = 1'b1; req_op = 0; req_idx = 6; req_node = 1;
        @(posedge clk); #1;
        cpu_we = 1'b0; req_valid = 1'b0;
        chk("R9 clash busy", {rsp_valid, rsp_code}, {1'b1, 2'd2});
        peek(6, d); chk("R10 R9 cpu write wins", d, w);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_fill();
        t_overflow();
        t_software();
        t_write_shared();
        t_write_alone();
        t_excl();
        t_stray_ack();
        t_clash();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule